// File: doc/BRIEF.md
# Bus-Mapped PWM Generator with Selectable Count Rate

This block is a pulse-width modulator that sits on the 16-bit memory bus of a small microcontroller. Software sets it up with three word writes. A configuration word selects the rate at which the period counter advances. A limit word sets the period. A threshold word sets the duty cycle. The block has no other control path, and any of the three words can be changed at any time while it runs.

One fast system clock drives everything. The five count rates come in as clock-enable pulses, each synchronous to that clock, at 1x, 2x, 4x, 8x and 16x a base rate. The 16x enable is high on every cycle. Each selected pulse advances a 16-bit counter by one. When the counter has reached the limit word, the next pulse returns it to zero. The output is high while the counter is below the threshold word.

Each instance decodes a 16-word window on the bus. A parameter sets its base address, which defaults to 16400. A second and a third instance would sit at 16416 and 16432. Every register in the block uses the same asynchronous active-low reset, and that reset is released synchronously to the clock.

Top module: `pwm_mmio`

## Requirements
- R1: While reset is held and right after it, the configuration, limit, threshold and counter are all zero, `pwm_out` is low, and `bus_rdata` is zero.
- R2: A write lands only when `bus_addr[15:4]` equals the base address bits [15:4]. Offset 0 writes the rate code, offset 1 writes the limit, and offset 2 writes the threshold. A write to any other offset or window changes nothing.
- R3: `bus_rdata` shows the addressed register on the cycle after `bus_rd` is sampled. The rate code reads back in bits [2:0] with the upper bits zero. Unused offsets, other windows and cycles with no read all return zero.
- R4: Rate code k, for k from 0 to 4, connects `rate_en[k]` to the counter. Code 0 is the 1x rate and code 4 is the 16x rate. The counter changes only on a cycle where the selected enable is high.
- R5: Rate codes 5, 6 and 7 freeze the counter at its current value.
- R6: On a selected enable, if the counter is at or above the limit it returns to zero, and otherwise it increments. The period is therefore (limit+1) enable pulses.
- R7: `pwm_out` is high exactly while the counter is below the threshold. Over each period it is high for min(threshold, limit+1) enable intervals. A threshold of 0 keeps the output low.
- R8: A new limit or threshold takes effect on the cycle after the write, with no wait for the period to end.
- R9: Pulling `rst_n` low clears all state and drives `pwm_out` low without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, one cycle after the strobe |
| rate_en | input | 5 | Count-rate enables, bit k is 2^k times the base rate |
| pwm_out | output | 1 | Modulated output |

## Verification
The bound checker watches four properties on every cycle:
- the counter holds when no pulse is selected or a stop code is set;
- the counter steps by exactly one below the limit;
- the counter returns to zero at or above the limit;
- the rate code reads back one cycle after a read at the base address.

It also checks the output against a zero threshold and a zero count. The duty ratio for each rate and threshold is a property of whole periods, so only the bench's vectors can show it. They do this by counting high cycles over an exact number of periods. The bench also covers window decoding, the immediate effect of a write, and the reset that acts without a clock edge.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 16;
  localparam int CS_W      = 3;
  localparam int NUM_RATES = 5;
  localparam int WIN_BITS  = 4;

  typedef enum logic [1:0] {
    SEL_RATE  = 2'd0,
    SEL_LIMIT = 2'd1,
    SEL_THR   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int AW  = ADDR_W,
  parameter int CSW = CS_W,
  parameter int WB  = WIN_BITS,
  parameter logic [AW-1:0] BASE = AW'(16400)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  addr,
  input  logic           wr_en,
  input  logic [DW-1:0]  wr_data,
  input  logic           rd_en,
  output logic [DW-1:0]  rd_data,
  output logic [CSW-1:0] rate_q,
  output logic [DW-1:0]  limit_q,
  output logic [DW-1:0]  thr_q
);
  localparam int TAG_W = AW - WB;
  localparam logic [TAG_W-1:0] BASE_TAG = BASE[AW-1:WB];

  reg_sel_e       sel;
  logic [CSW-1:0] rate_d;
  logic [DW-1:0]  limit_d;
  logic [DW-1:0]  thr_d;
  logic [DW-1:0]  rd_d;

  always_comb begin
    sel = SEL_NONE;
    if (addr[AW-1:WB] == BASE_TAG) begin
      case (addr[WB-1:0])
        WB'(0):  sel = SEL_RATE;
        WB'(1):  sel = SEL_LIMIT;
        WB'(2):  sel = SEL_THR;
        default: sel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    rate_d  = rate_q;
    limit_d = limit_q;
    thr_d   = thr_q;
    if (wr_en) begin
      case (sel)
        SEL_RATE:  rate_d  = wr_data[CSW-1:0];
        SEL_LIMIT: limit_d = wr_data;
        SEL_THR:   thr_d   = wr_data;
        default:   ;
      endcase
    end
  end

  always_comb begin
    rd_d = '0;
    if (rd_en) begin
      case (sel)
        SEL_RATE:  rd_d = {{(DW-CSW){1'b0}}, rate_q};
        SEL_LIMIT: rd_d = limit_q;
        SEL_THR:   rd_d = thr_q;
        default:   rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q  <= '0;
      limit_q <= '0;
      thr_q   <= '0;
      rd_data <= '0;
    end else begin
      rate_q  <= rate_d;
      limit_q <= limit_d;
      thr_q   <= thr_d;
      rd_data <= rd_d;
    end
  end
endmodule

// File: rtl/pwm_rate_sel.sv
module pwm_rate_sel #(
  parameter int CSW   = 3,
  parameter int RATES = 5
) (
  input  logic [RATES-1:0] rate_en,
  input  logic [CSW-1:0]   code,
  output logic             tick
);
  logic [RATES-1:0] pick;

  for (genvar i = 0; i < RATES; i++) begin : g_rate
    assign pick[i] = rate_en[i] & (code == CSW'(i));
  end

  assign tick = |pick;
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [DW-1:0] limit,
  input  logic [DW-1:0] thr,
  output logic [DW-1:0] cnt_q,
  output logic          pwm
);
  logic [DW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick) begin
      if (cnt_q >= limit) cnt_d = '0;
      else                cnt_d = cnt_q + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pwm = (cnt_q < thr);
endmodule

// File: rtl/pwm_mmio.sv
module pwm_mmio
  import pwm_pkg::*;
#(
  parameter int BASE_ADDR = 16400
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic                 bus_rd,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_RATES-1:0] rate_en,
  output logic                 pwm_out
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

  logic              rst_sync_n;
  logic [CS_W-1:0]   rate_code;
  logic [DATA_W-1:0] limit_val;
  logic [DATA_W-1:0] thr_val;
  logic [DATA_W-1:0] cnt_val;
  logic              tick;

  pwm_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  pwm_regs #(
    .DW(DATA_W), .AW(ADDR_W), .CSW(CS_W), .WB(WIN_BITS), .BASE(BASE)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .addr    (bus_addr),
    .wr_en   (bus_wr),
    .wr_data (bus_wdata),
    .rd_en   (bus_rd),
    .rd_data (bus_rdata),
    .rate_q  (rate_code),
    .limit_q (limit_val),
    .thr_q   (thr_val)
  );

  pwm_rate_sel #(.CSW(CS_W), .RATES(NUM_RATES)) u_sel (
    .rate_en (rate_en),
    .code    (rate_code),
    .tick    (tick)
  );

  pwm_core #(.DW(DATA_W)) u_core (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (tick),
    .limit (limit_val),
    .thr   (thr_val),
    .cnt_q (cnt_val),
    .pwm   (pwm_out)
  );
endmodule

// File: rtl/pwm_mmio_chk.sv
module pwm_mmio_chk #(
  parameter int DW  = 16,
  parameter int AW  = 16,
  parameter int CSW = 3,
  parameter int RATES = 5,
  parameter logic [AW-1:0] BASE = AW'(16400)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic [CSW-1:0] code,
  input logic [DW-1:0]  cnt,
  input logic [DW-1:0]  limit,
  input logic [DW-1:0]  thr,
  input logic           pwm,
  input logic           rd_en,
  input logic [AW-1:0]  addr,
  input logic [DW-1:0]  rd_data
);
  // R4: no selected pulse, no movement
  assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  // R5: stop codes freeze the counter
  assert_stop_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (code >= CSW'(RATES)) |=> $stable(cnt));

  // R6: increment below the limit
  assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt < limit) |=> (cnt == $past(cnt) + DW'(1)));

  // R6: return to zero at or above the limit
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt >= limit) |=> (cnt == '0));

  // R7: zero threshold keeps the output low
  assert_zero_thr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (thr == '0) |-> !pwm);

  // R7: count zero with a nonzero threshold drives the output high
  assert_start_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && thr != '0) |-> pwm);

  // R3: rate code read back one cycle later
  assert_rate_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == BASE) |=> (rd_data == {{(DW-CSW){1'b0}}, $past(code)}));
endmodule

bind pwm_mmio pwm_mmio_chk #(
  .DW(pwm_pkg::DATA_W), .AW(pwm_pkg::ADDR_W), .CSW(pwm_pkg::CS_W),
  .RATES(pwm_pkg::NUM_RATES), .BASE(BASE)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .tick    (tick),
  .code    (rate_code),
  .cnt     (cnt_val),
  .limit   (limit_val),
  .thr     (thr_val),
  .pwm     (pwm_out),
  .rd_en   (bus_rd),
  .addr    (bus_addr),
  .rd_data (bus_rdata)
);

// File: tb/tb_pwm_mmio.sv
`timescale 1ns/1ps
module tb_pwm_mmio;
  localparam int BASE  = 16400;
  localparam int VEC_N = 12;
  // {rate code, limit, threshold, periods}; periods 0 means a 64-cycle window
  localparam logic [63:0] VEC [VEC_N] = '{
    {16'd4, 16'd3,  16'd2, 16'd4},
    {16'd4, 16'd9,  16'd0, 16'd2},
    {16'd4, 16'd5,  16'd7, 16'd3},
    {16'd3, 16'd4,  16'd1, 16'd3},
    {16'd2, 16'd7,  16'd3, 16'd2},
    {16'd1, 16'd2,  16'd2, 16'd2},
    {16'd0, 16'd1,  16'd1, 16'd2},
    {16'd5, 16'd10, 16'd1, 16'd0},
    {16'd7, 16'd10, 16'd0, 16'd0},
    {16'd4, 16'd0,  16'd1, 16'd5},
    {16'd6, 16'd3,  16'd1, 16'd0},
    {16'd4, 16'd6,  16'd6, 16'd2}
  };

  logic        clk;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic        bus_wr;
  logic [15:0] bus_wdata;
  logic        bus_rd;
  logic [15:0] bus_rdata;
  logic [4:0]  rate_en;
  logic        pwm_out;
  logic [3:0]  div;

  int n_chk;
  int n_fail;
  bit done;

  pwm_mmio #(.BASE_ADDR(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .rate_en(rate_en), .pwm_out(pwm_out)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  // enables: bit k pulses once every 2^(4-k) cycles
  initial begin
    div = '0;
    rate_en = 5'b11111;
    forever begin
      @(negedge clk);
      div = div + 4'd1;
      rate_en = {1'b1, div[0] == 1'b0, div[1:0] == 2'd0,
                 div[2:0] == 3'd0, div[3:0] == 4'd0};
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_write(input int a, input int d);
    @(negedge clk);
    bus_addr = 16'(a); bus_wdata = 16'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output int d);
    @(negedge clk);
    bus_addr = 16'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = int'(bus_rdata);
  endtask

  task automatic count_high(input int w, output int hi);
    hi = 0;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int rd, hi;
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; bus_rd = 1'b0;

    // duty vectors: R4 R5 R6 R7
    for (int v = 0; v < VEC_N; v++) begin
      int code, lim, thr, per, dv, w, exp;
      code = int'(VEC[v][63:48]); lim = int'(VEC[v][47:32]);
      thr  = int'(VEC[v][31:16]); per = int'(VEC[v][15:0]);
      do_reset();
      bus_write(BASE, code);
      bus_write(BASE + 1, lim);
      bus_write(BASE + 2, thr);
      repeat (4) @(negedge clk);
      if (code > 4) begin
        w = 64;
        exp = (thr > 0) ? w : 0;
      end else begin
        dv = 1 << (4 - code);
        w = (lim + 1) * dv * per;
        exp = ((thr < lim + 1) ? thr : lim + 1) * dv * per;
      end
      count_high(w, hi);
      check(hi == exp, (code > 4) ? "R5 stop" : "R4/R6/R7 duty", hi, exp);
    end

    // R1: reset state
    rst_n = 1'b0;
    #1;
    check(pwm_out == 1'b0, "R1 pwm in reset", int'(pwm_out), 0);
    check(bus_rdata == 16'd0, "R1 rdata in reset", int'(bus_rdata), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(BASE, rd);     check(rd == 0, "R1 rate zero", rd, 0);
    bus_read(BASE + 1, rd); check(rd == 0, "R1 limit zero", rd, 0);
    bus_read(BASE + 2, rd); check(rd == 0, "R1 thr zero", rd, 0);

    // R3 / R2: readback and decode
    bus_write(BASE, 16'hFFFF);
    bus_write(BASE + 1, 16'h1234);
    bus_write(BASE + 2, 16'hBEEF);
    bus_read(BASE, rd);     check(rd == 7, "R3 rate field", rd, 7);
    bus_read(BASE + 1, rd); check(rd == 16'h1234, "R3 limit read", rd, 16'h1234);
    bus_read(BASE + 2, rd); check(rd == 16'hBEEF, "R3 thr read", rd, 16'hBEEF);
    @(negedge clk);
    check(bus_rdata == 16'd0, "R3 idle read zero", int'(bus_rdata), 0);
    bus_read(BASE + 3, rd); check(rd == 0, "R3 unused offset", rd, 0);
    bus_write(BASE + 16 + 2, 5);
    bus_write(BASE + 3, 9);
    bus_read(BASE + 2, rd); check(rd == 16'hBEEF, "R2 other window ignored", rd, 16'hBEEF);
    bus_read(BASE + 16 + 2, rd); check(rd == 0, "R2 other window read", rd, 0);
    bus_write(BASE + 32 + 1, 3);
    bus_read(BASE + 1, rd); check(rd == 16'h1234, "R2 third window ignored", rd, 16'h1234);

    // R8: immediate threshold update
    do_reset();
    bus_write(BASE, 4);
    bus_write(BASE + 1, 3);
    repeat (5) @(negedge clk);
    check(pwm_out == 1'b0, "R8 low before", int'(pwm_out), 0);
    bus_write(BASE + 2, 4);
    check(pwm_out == 1'b1, "R8 high next cycle", int'(pwm_out), 1);

    // R9: asynchronous clear
    @(posedge clk);
    #3 rst_n = 1'b0;
    #1 check(pwm_out == 1'b0, "R9 async clear", int'(pwm_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R5: stop mid-run keeps the output constant
    bus_write(BASE + 1, 9);
    bus_write(BASE + 2, 5);
    bus_write(BASE, 4);
    repeat (7) @(negedge clk);
    bus_write(BASE, 6);
    count_high(50, hi);
    check(hi == 0 || hi == 50, "R5 frozen mid-run", hi, 50);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule